// File: doc/BRIEF.md
# USB OUT Endpoint Receive Controller

This block runs one receive endpoint of a USB device function and owns that endpoint's 64-byte receive FIFO. A packet engine, which is outside this block, decodes the bus traffic. It passes the block token events, one data byte at a time, and an end-of-packet strobe. That strobe either marks a clean packet or reports a media error.

The block decides which handshake to return: ACK, NAK, STALL or none. It stores accepted bytes and publishes a packet only when the packet ends cleanly. A packet that fails for any reason is rolled back, so none of its bytes become visible.

Software controls the endpoint through a command word and a read-to-clear status byte, and drains the FIFO through a simple read strobe. Reception disarms itself after every accepted OUT packet and after every STALL, so software must re-arm the endpoint each time. SETUP packets are accepted without arming. A near-full output warns when the free space in the FIFO falls to a selectable threshold.

Top module: `usb_out_ep_rx`

## Requirements
- R1: After reset the FIFO count is 0, `hs_valid`, `rx_armed` and `near_full` are 0, and the status byte reads 0.
- R2: An OUT packet that arrives while armed, with enough free space, is stored. `hs_valid` pulses with `hs_code` = 0 (ACK) in the cycle after the `pkt_end` edge, `fifo_count` grows by the packet length in that same cycle, and `rx_armed` clears. Bytes read out through `fifo_rd` appear in the order they were received.
- R3: An OUT packet that arrives while unarmed gets `hs_code` = 1 (NAK), and the FIFO is left unchanged.
- R4: While `ep_stall` is high, an OUT packet gets `hs_code` = 2 (STALL), and `rx_armed` clears.
- R5: A SETUP packet is accepted and ACKed whether or not the endpoint is armed. Its bytes are stored, and status bit 0 (setup seen) is set.
- R6: A SETUP that follows an accepted SETUP, with no OUT or other token in between, is discarded and still ACKed. The FIFO is unchanged. Any non-SETUP token ends this condition.
- R7: While command bit 1 (ignore SETUP) is set, a SETUP produces no handshake, stores no data and sets no status bit.
- R8: A packet longer than the free space is rolled back in full. An OUT gets NAK and a SETUP gets no handshake. A packet that exactly fills the FIFO is accepted.
- R9: A packet ended by `pkt_err` while data is being received gets no handshake and is rolled back, and status bit 1 (receive error) is set. The armed state is not changed.
- R10: Writing command bit 2 (flush) while idle empties the FIFO two clock edges after the write. A flush written during a packet waits until that packet ends, and is then carried out.
- R11: Command bits 4:3 select the warning limit: 00 off, 01 four bytes, 10 eight bytes, 11 sixteen bytes. `near_full` is high exactly when the limit is on and the free bytes, counting any in-flight packet, are less than or equal to the limit.
- R12: Status bits 0..2 clear on the edge that ends a `sts_rd` cycle, unless the same edge sets them again. Command bit 0 arms the endpoint.
- R13: With `iso_mode` high, status bit 2 takes the value of `frame_lsb` when a packet is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tok_valid | input | 1 | Token event strobe |
| tok_kind | input | 2 | 0 OUT, 1 SETUP, 2 or 3 any other token |
| byte_valid | input | 1 | Data byte strobe |
| byte_data | input | 8 | Data byte |
| pkt_end | input | 1 | Clean end of data packet |
| pkt_err | input | 1 | End of data packet with a media error |
| ep_stall | input | 1 | Endpoint is halted |
| iso_mode | input | 1 | Isochronous endpoint |
| frame_lsb | input | 1 | Least significant bit of the current frame number |
| cmd_wr | input | 1 | Command write strobe |
| cmd_wdata | input | 8 | Command word: bit0 arm, bit1 ignore SETUP, bit2 flush, bits4:3 warning limit |
| sts_rd | input | 1 | Status read strobe (clears the status bits) |
| sts_rdata | output | 8 | Status: bit0 setup seen, bit1 receive error, bit2 frame bit |
| rx_armed | output | 1 | OUT reception is enabled |
| fifo_rd | input | 1 | Pop one byte |
| fifo_rdata | output | 8 | Byte at the head of the FIFO |
| fifo_count | output | 7 | Committed bytes available to read |
| near_full | output | 1 | Free space is at or below the warning limit |
| hs_valid | output | 1 | Handshake strobe |
| hs_code | output | 2 | 0 ACK, 1 NAK, 2 STALL |

## Verification
The handshake is registered, so it appears in the cycle after the rising edge that samples `pkt_end` or `pkt_err`. The FIFO count, the armed bit and the status bits change on that same edge. `near_full` follows each byte edge at once. An idle flush needs a second edge after the command write. The bench drives every input just after a falling edge and samples half a cycle after the edge on which each result is due. It reads the combinational status and the head byte before the edge that consumes them. A reference model in the bench predicts every handshake, count, flag and warning level. The bench checks these during random traffic and also in directed cases for overflow, exact fill, deferred flush, repeated SETUP and the warning limits.

// File: rtl/usb_rx_pkg.sv
package usb_rx_pkg;
  typedef enum logic [1:0] {TOK_OUT = 2'd0, TOK_SETUP = 2'd1, TOK_OTHER = 2'd2} tok_e;
  typedef enum logic [1:0] {HS_ACK = 2'd0, HS_NAK = 2'd1, HS_STALL = 2'd2} hs_e;
  typedef enum logic [1:0] {ST_IDLE, ST_OUT, ST_SETUP, ST_SINK} rx_st_e;

  localparam int CMD_ARM    = 0;
  localparam int CMD_IGN    = 1;
  localparam int CMD_FLUSH  = 2;
  localparam int CMD_LIM_LO = 3;

  // threshold in bytes for a warning-limit code
  function automatic logic [4:0] warn_bytes(input logic [1:0] code);
    case (code)
      2'd1:    return 5'd4;
      2'd2:    return 5'd8;
      2'd3:    return 5'd16;
      default: return 5'd0;
    endcase
  endfunction

  function automatic logic near_full_hit(input int unsigned free, input logic [1:0] code);
    return (code != 2'd0) && (free <= 32'(warn_bytes(code)));
  endfunction
endpackage

// File: rtl/usb_rx_fifo.sv
module usb_rx_fifo
  import usb_rx_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          wr_en,
  input  logic [7:0]    wr_data,
  input  logic          commit,
  input  logic          rollback,
  input  logic          rd_en,
  input  logic [1:0]    lim_code,
  output logic [7:0]    rd_data,
  output logic [AW:0]   count,
  output logic          full,
  output logic          near_full
);
  logic [AW:0] wr_ptr, cm_ptr, rd_ptr;
  logic [AW:0] used, free;
  logic [7:0]  mem [DEPTH];
  logic        wr_ok, rd_ok;

  assign used      = wr_ptr - rd_ptr;
  assign free      = (AW+1)'(DEPTH) - used;
  assign count     = cm_ptr - rd_ptr;
  assign full      = (used == (AW+1)'(DEPTH));
  assign wr_ok     = wr_en && !full && !flush;
  assign rd_ok     = rd_en && (count != '0) && !flush;
  assign rd_data   = mem[rd_ptr[AW-1:0]];
  assign near_full = near_full_hit(32'(free), lim_code);

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wr_ptr[AW-1:0]] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wr_ptr <= '0;
      cm_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (wr_ok)         wr_ptr <= wr_ptr + 1'b1;
      else if (rollback) wr_ptr <= cm_ptr;
      if (commit)        cm_ptr <= wr_ptr;
      if (rd_ok)         rd_ptr <= rd_ptr + 1'b1;
    end
  end

  // R8: occupancy never exceeds the storage
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    used <= (AW+1)'(DEPTH));
  // R10: a flush leaves nothing stored
  p_flush_empties_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (used == '0 && count == '0));
  // R9: a rollback returns the write side to the committed point
  p_rollback_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rollback && !commit && !wr_en && !flush) |=> (wr_ptr == $past(cm_ptr)));
endmodule

// File: rtl/usb_rx_ctrl.sv
module usb_rx_ctrl
  import usb_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tok_valid,
  input  logic [1:0] tok_kind,
  input  logic       byte_valid,
  input  logic       pkt_end,
  input  logic       pkt_err,
  input  logic       ep_stall,
  input  logic       cmd_wr,
  input  logic [7:0] cmd_wdata,
  input  logic       fifo_full,
  output logic       fifo_wr,
  output logic       fifo_commit,
  output logic       fifo_rollback,
  output logic       fifo_flush,
  output logic       rx_armed,
  output logic [1:0] lim_code,
  output logic       hs_valid,
  output logic [1:0] hs_code,
  output logic       ev_setup_ok,
  output logic       ev_out_ok,
  output logic       ev_media_err
);
  rx_st_e state;
  hs_e    sink_hs, hs_nc;
  logic   sink_hs_vld, hs_nv;
  logic   ovf, setup_seen, ign, flush_pend;
  logic   receiving, done, ovf_now, bad, good_end, stall_sent;

  assign receiving     = (state == ST_OUT) || (state == ST_SETUP);
  assign done          = (pkt_end || pkt_err) && (state != ST_IDLE);
  assign fifo_wr       = receiving && byte_valid && !fifo_full && !ovf;
  assign ovf_now       = receiving && byte_valid && fifo_full;
  assign bad           = ovf || ovf_now;
  assign good_end      = receiving && pkt_end && !pkt_err && !bad;
  assign ev_out_ok     = good_end && (state == ST_OUT);
  assign ev_setup_ok   = good_end && (state == ST_SETUP);
  assign ev_media_err  = receiving && pkt_err;
  assign fifo_commit   = good_end;
  assign fifo_rollback = receiving && (((pkt_end || pkt_err) && !good_end) || tok_valid);
  assign fifo_flush    = flush_pend && (state == ST_IDLE) && !tok_valid;
  assign stall_sent    = hs_nv && (hs_nc == HS_STALL);

  always_comb begin
    hs_nv = 1'b0;
    hs_nc = HS_ACK;
    if (done && !pkt_err) begin
      case (state)
        ST_OUT:   begin hs_nv = 1'b1; hs_nc = bad ? HS_NAK : HS_ACK; end
        ST_SETUP: begin hs_nv = !bad; hs_nc = HS_ACK; end
        ST_SINK:  begin hs_nv = sink_hs_vld; hs_nc = sink_hs; end
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE; sink_hs <= HS_ACK; sink_hs_vld <= 1'b0;
      ovf <= 1'b0; setup_seen <= 1'b0; ign <= 1'b0; flush_pend <= 1'b0;
      rx_armed <= 1'b0; lim_code <= 2'd0; hs_valid <= 1'b0; hs_code <= 2'd0;
    end else begin
      hs_valid <= hs_nv;
      hs_code  <= hs_nc;
      if (cmd_wr) begin
        rx_armed <= cmd_wdata[CMD_ARM];
        ign      <= cmd_wdata[CMD_IGN];
        lim_code <= cmd_wdata[CMD_LIM_LO +: 2];
      end else if (ev_out_ok || stall_sent) begin
        rx_armed <= 1'b0;
      end
      if (cmd_wr && cmd_wdata[CMD_FLUSH]) flush_pend <= 1'b1;
      else if (fifo_flush)                flush_pend <= 1'b0;
      if (ovf_now)     ovf <= 1'b1;
      if (ev_setup_ok) setup_seen <= 1'b1;
      if (tok_valid) begin
        ovf <= 1'b0;
        case (tok_kind)
          TOK_OUT: begin
            setup_seen <= 1'b0;
            if (ep_stall) begin
              state <= ST_SINK; sink_hs_vld <= 1'b1; sink_hs <= HS_STALL;
            end else if (!rx_armed) begin
              state <= ST_SINK; sink_hs_vld <= 1'b1; sink_hs <= HS_NAK;
            end else begin
              state <= ST_OUT;
            end
          end
          TOK_SETUP: begin
            if (ign) begin
              state <= ST_SINK; sink_hs_vld <= 1'b0; sink_hs <= HS_ACK;
            end else if (setup_seen) begin
              state <= ST_SINK; sink_hs_vld <= 1'b1; sink_hs <= HS_ACK;
            end else begin
              state <= ST_SETUP;
            end
          end
          default: begin
            setup_seen <= 1'b0;
            state      <= ST_IDLE;
          end
        endcase
      end else if (done) begin
        state <= ST_IDLE;
      end
    end
  end

  // R2: handshakes only follow a clean packet end
  p_hs_after_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hs_valid |-> $past(pkt_end));
  // R2: accepted OUT data disarms the endpoint
  p_disarm_after_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_out_ok && !cmd_wr) |=> !rx_armed);
  // R9: media error never gets a handshake
  p_err_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_err && state != ST_IDLE) |=> !hs_valid);
  // R7: ignored SETUP leads to a silent sink
  p_ign_setup_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_valid && tok_kind == TOK_SETUP && ign) |=> (state == ST_SINK && !sink_hs_vld));
  // R4: halted endpoint answers OUT with STALL
  p_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_valid && tok_kind == TOK_OUT && ep_stall) |=> (state == ST_SINK && sink_hs == HS_STALL));
  // R6: repeated SETUP is dropped but acknowledged
  p_setup_repeat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_valid && tok_kind == TOK_SETUP && !ign && setup_seen)
      |=> (state == ST_SINK && sink_hs_vld && sink_hs == HS_ACK));
endmodule

// File: rtl/usb_rx_status.sv
module usb_rx_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ev_setup_ok,
  input  logic       ev_out_ok,
  input  logic       ev_media_err,
  input  logic       iso_mode,
  input  logic       frame_lsb,
  input  logic       sts_rd,
  output logic [7:0] sts_rdata
);
  logic setup_f, err_f, frame_f;

  assign sts_rdata = {5'd0, frame_f, err_f, setup_f};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      setup_f <= 1'b0; err_f <= 1'b0; frame_f <= 1'b0;
    end else begin
      if (ev_setup_ok)  setup_f <= 1'b1;
      else if (sts_rd)  setup_f <= 1'b0;
      if (ev_media_err) err_f <= 1'b1;
      else if (sts_rd)  err_f <= 1'b0;
      if (iso_mode && (ev_setup_ok || ev_out_ok)) frame_f <= frame_lsb;
      else if (sts_rd)                            frame_f <= 1'b0;
    end
  end

  // R12: a read with no concurrent event leaves the status clear
  p_read_clears_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_rd && !ev_setup_ok && !ev_out_ok && !ev_media_err) |=> (sts_rdata == 8'd0));
endmodule

// File: rtl/usb_out_ep_rx.sv
module usb_out_ep_rx
  import usb_rx_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tok_valid,
  input  logic [1:0]    tok_kind,
  input  logic          byte_valid,
  input  logic [7:0]    byte_data,
  input  logic          pkt_end,
  input  logic          pkt_err,
  input  logic          ep_stall,
  input  logic          iso_mode,
  input  logic          frame_lsb,
  input  logic          cmd_wr,
  input  logic [7:0]    cmd_wdata,
  input  logic          sts_rd,
  output logic [7:0]    sts_rdata,
  output logic          rx_armed,
  input  logic          fifo_rd,
  output logic [7:0]    fifo_rdata,
  output logic [AW:0]   fifo_count,
  output logic          near_full,
  output logic          hs_valid,
  output logic [1:0]    hs_code
);
  logic       fifo_wr, fifo_commit, fifo_rollback, fifo_flush, fifo_full;
  logic [1:0] lim_code;
  logic       ev_setup_ok, ev_out_ok, ev_media_err;

  usb_rx_ctrl u_ctrl (
    .clk, .rst_n, .tok_valid, .tok_kind, .byte_valid, .pkt_end, .pkt_err, .ep_stall,
    .cmd_wr, .cmd_wdata, .fifo_full, .fifo_wr, .fifo_commit, .fifo_rollback,
    .fifo_flush, .rx_armed, .lim_code, .hs_valid, .hs_code,
    .ev_setup_ok, .ev_out_ok, .ev_media_err
  );

  usb_rx_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk, .rst_n, .flush(fifo_flush), .wr_en(fifo_wr), .wr_data(byte_data),
    .commit(fifo_commit), .rollback(fifo_rollback), .rd_en(fifo_rd),
    .lim_code, .rd_data(fifo_rdata), .count(fifo_count), .full(fifo_full),
    .near_full
  );

  usb_rx_status u_status (
    .clk, .rst_n, .ev_setup_ok, .ev_out_ok, .ev_media_err, .iso_mode, .frame_lsb,
    .sts_rd, .sts_rdata
  );

  // R3: an unarmed OUT never commits data
  p_nak_keeps_fifo_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_valid && hs_code == HS_NAK) |-> $stable(fifo_count) || $past(fifo_rd) || $past(fifo_flush));
endmodule

// File: tb/usb_out_ep_rx_tb.sv
module usb_out_ep_rx_tb;
  localparam int DEPTH = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tok_valid = 0, byte_valid = 0, pkt_end = 0, pkt_err = 0;
  logic [1:0] tok_kind = 0;
  logic [7:0] byte_data = 0, cmd_wdata = 0;
  logic ep_stall = 0, iso_mode = 0, frame_lsb = 0, cmd_wr = 0, sts_rd = 0, fifo_rd = 0;
  logic [7:0] sts_rdata, fifo_rdata;
  logic [6:0] fifo_count;
  logic rx_armed, near_full, hs_valid;
  logic [1:0] hs_code;

  always #5 clk = ~clk;

  usb_out_ep_rx #(.DEPTH(DEPTH)) u_dut (
    .clk, .rst_n, .tok_valid, .tok_kind, .byte_valid, .byte_data, .pkt_end, .pkt_err,
    .ep_stall, .iso_mode, .frame_lsb, .cmd_wr, .cmd_wdata, .sts_rd, .sts_rdata,
    .rx_armed, .fifo_rd, .fifo_rdata, .fifo_count, .near_full, .hs_valid, .hs_code
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  // reference model state
  byte unsigned mq[$];
  bit m_arm, m_ign, m_seen, m_set, m_err, m_fr;
  logic [1:0] m_lim;

  task automatic tick(); @(negedge clk); endtask

  task automatic check(input string req, input string what, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
    end
  endtask

  function automatic int lim_bytes(input logic [1:0] c);
    return (c == 2'd0) ? 0 : (2 << c);
  endfunction

  function automatic bit exp_warn(input int used);
    return (m_lim != 2'd0) && ((DEPTH - used) <= lim_bytes(m_lim));
  endfunction

  task automatic wr_cmd(input bit arm, input bit ign, input bit flush, input logic [1:0] lim);
    cmd_wr = 1; cmd_wdata = {3'd0, lim, flush, ign, arm};
    tick(); cmd_wr = 0;
    m_arm = arm; m_ign = ign; m_lim = lim;
    if (flush) begin tick(); mq.delete(); end
  endtask

  task automatic rd_status(input string req);
    sts_rd = 1;
    #1 check(req, "status", int'(sts_rdata), int'({m_fr, m_err, m_set}));
    tick(); sts_rd = 0;
    m_set = 0; m_err = 0; m_fr = 0;
  endtask

  task automatic drain(input int n, input string req);
    for (int i = 0; i < n && mq.size() > 0; i++) begin
      fifo_rd = 1;
      #1 check(req, "fifo_rdata", int'(fifo_rdata), int'(mq.pop_front()));
      tick();
    end
    fifo_rd = 0;
    check(req, "count after read", int'(fifo_count), mq.size());
  endtask

  task automatic run_pkt(input logic [1:0] kind, input int len, input bit err, input string req);
    byte unsigned d[$];
    int cap = DEPTH - mq.size();
    int exp = -1;
    bit push = 0;
    if (kind == 2'd0) begin
      m_seen = 0;
      if (ep_stall) begin if (!err) begin exp = 2; m_arm = 0; end end
      else if (!m_arm) begin if (!err) exp = 1; end
      else if (err) m_err = 1;
      else if (len > cap) exp = 1;
      else begin exp = 0; push = 1; m_arm = 0; end
    end else if (kind == 2'd1) begin
      if (m_ign) exp = -1;
      else if (m_seen) begin if (!err) exp = 0; end
      else if (err) m_err = 1;
      else if (len > cap) exp = -1;
      else begin exp = 0; push = 1; m_set = 1; m_seen = 1; end
    end else m_seen = 0;
    if (push && iso_mode) m_fr = frame_lsb;

    tok_valid = 1; tok_kind = kind; tick(); tok_valid = 0;
    if (kind < 2'd2) begin
      for (int i = 0; i < len; i++) begin
        byte unsigned b = 8'($urandom);
        d.push_back(b);
        byte_valid = 1; byte_data = b; tick();
      end
      byte_valid = 0;
      if (err) pkt_err = 1; else pkt_end = 1;
      tick(); pkt_err = 0; pkt_end = 0;
      check(req, "hs_valid", int'(hs_valid), (exp >= 0) ? 1 : 0);
      if (exp >= 0) check(req, "hs_code", int'(hs_code), exp);
      if (push) foreach (d[i]) mq.push_back(d[i]);
    end
    check(req, "fifo_count", int'(fifo_count), mq.size());
    check(req, "rx_armed", int'(rx_armed), int'(m_arm));
    check("R11", "near_full", int'(near_full), int'(exp_warn(mq.size())));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7781));
    m_arm = 0; m_ign = 0; m_seen = 0; m_set = 0; m_err = 0; m_fr = 0; m_lim = 0;
    repeat (3) tick();
    rst_n = 1;
    tick();
    // R1 reset state
    check("R1", "count", int'(fifo_count), 0);
    check("R1", "hs_valid", int'(hs_valid), 0);
    check("R1", "rx_armed", int'(rx_armed), 0);
    check("R1", "near_full", int'(near_full), 0);
    check("R1", "status", int'(sts_rdata), 0);

    run_pkt(2'd0, 4, 0, "R3");                 // unarmed OUT -> NAK
    wr_cmd(1, 0, 0, 2'd0);
    check("R12", "arm bit", int'(rx_armed), 1);
    run_pkt(2'd0, 5, 0, "R2");                 // armed OUT -> ACK, disarm
    drain(5, "R2");
    run_pkt(2'd1, 3, 0, "R5");                 // SETUP while unarmed
    run_pkt(2'd1, 6, 0, "R6");                 // repeated SETUP dropped
    run_pkt(2'd0, 2, 0, "R6");                 // OUT ends the repeat window
    run_pkt(2'd1, 2, 0, "R6");                 // SETUP accepted again
    rd_status("R5");
    rd_status("R12");
    wr_cmd(0, 1, 0, 2'd0);
    run_pkt(2'd2, 0, 0, "R7");
    run_pkt(2'd1, 4, 0, "R7");                 // ignored SETUP
    rd_status("R7");
    wr_cmd(1, 0, 0, 2'd0);
    ep_stall = 1;
    run_pkt(2'd0, 3, 0, "R4");
    ep_stall = 0;
    wr_cmd(1, 0, 0, 2'd0);
    run_pkt(2'd0, 6, 1, "R9");                 // media error
    rd_status("R9");
    wr_cmd(0, 0, 1, 2'd0);
    check("R10", "idle flush", int'(fifo_count), 0);

    // R10 deferred flush
    wr_cmd(1, 0, 0, 2'd0);
    run_pkt(2'd0, 4, 0, "R10");
    wr_cmd(1, 0, 0, 2'd0);
    tok_valid = 1; tok_kind = 2'd0; tick(); tok_valid = 0;
    for (int i = 0; i < 3; i++) begin byte_valid = 1; byte_data = 8'(i); tick(); end
    byte_valid = 0;
    cmd_wr = 1; cmd_wdata = 8'b0000_0101; tick(); cmd_wr = 0;
    tick(); tick();
    check("R10", "count held during packet", int'(fifo_count), 4);
    pkt_end = 1; tick(); pkt_end = 0;
    check("R10", "ack before flush", int'(hs_valid), 1);
    tick();
    check("R10", "deferred flush", int'(fifo_count), 0);
    mq.delete(); m_arm = 0; m_seen = 0;

    // R11 warning threshold, R8 overflow
    wr_cmd(1, 0, 0, 2'd3);
    tok_valid = 1; tok_kind = 2'd0; tick(); tok_valid = 0;
    for (int i = 0; i < 48; i++) begin
      byte unsigned b = 8'($urandom);
      mq.push_back(b);
      byte_valid = 1; byte_data = b; tick();
      if (i == 46) check("R11", "warn at 17 free", int'(near_full), 0);
      if (i == 47) check("R11", "warn at 16 free", int'(near_full), 1);
    end
    byte_valid = 0; pkt_end = 1; tick(); pkt_end = 0;
    check("R2", "hs_code", int'(hs_code), 0);
    m_arm = 0;
    wr_cmd(1, 0, 0, 2'd2);
    check("R11", "limit 8 at 16 free", int'(near_full), 0);
    wr_cmd(1, 0, 0, 2'd0);
    check("R11", "limit off", int'(near_full), 0);
    run_pkt(2'd0, 20, 0, "R8");                // overflow OUT -> NAK
    run_pkt(2'd1, 20, 0, "R8");                // overflow SETUP -> silent
    wr_cmd(1, 0, 0, 2'd1);
    run_pkt(2'd0, 16, 0, "R8");                // exact fill accepted
    check("R8", "full count", int'(fifo_count), DEPTH);
    drain(64, "R2");
    rd_status("R12");

    // R13 isochronous frame bit
    iso_mode = 1; frame_lsb = 1;
    wr_cmd(1, 0, 0, 2'd0);
    run_pkt(2'd0, 2, 0, "R13");
    rd_status("R13");
    rd_status("R12");

    // random traffic against the model
    for (int it = 0; it < 400; it++) begin
      int op = $urandom_range(0, 9);
      ep_stall  = ($urandom_range(0, 9) == 0);
      iso_mode  = $urandom_range(0, 1) == 1;
      frame_lsb = $urandom_range(0, 1) == 1;
      if (op <= 5) begin
        int r = $urandom_range(0, 19);
        logic [1:0] k = (r < 12) ? 2'd0 : (r < 17) ? 2'd1 : 2'($urandom_range(2, 3));
        int len = ($urandom_range(0, 9) == 0) ? $urandom_range(20, 40) : $urandom_range(0, 10);
        run_pkt(k, len, $urandom_range(0, 9) == 0, "R2");
      end else if (op == 6) drain($urandom_range(1, 8), "R2");
      else if (op == 7) rd_status("R12");
      else if (op == 8) wr_cmd($urandom_range(0, 3) != 0, $urandom_range(0, 7) == 0, 0,
                               2'($urandom_range(0, 3)));
      else begin
        wr_cmd(m_arm, m_ign, $urandom_range(0, 3) == 0, m_lim);
        check("R10", "count", int'(fifo_count), mq.size());
      end
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule